// File: doc/BRIEF.md
# ADC calibration mode sequencer

This block is the control sequencer of a sigma-delta converter. A host writes a 3-bit mode field, and that field chooses one of three behaviours. The first is plain conversion. The second is a one-shot system-offset calibration. The third is a background mode that interleaves offset calibration with conversion. The analog modulator and the digital filter are not part of the block. They appear only as two periodic ticks: one marks each output-rate period, and one marks each modulator cycle.

From these ticks the sequencer does four things. It selects which phase the filter is working on: zero-scale, full-scale or signal. It pulses strobes that tell the coefficient arithmetic to take a new offset or gain value. It marks each fresh data word. It drives an active-low data-ready flag for the host.

A system-offset calibration runs three steps of a fixed number of output periods each: a zero-scale step on the external input, a full-scale step on the internal reference, and a signal conversion. The mode field clears itself as soon as the two calibration steps are done. Data-ready reports a valid word only after the signal step.

Top module: `cal_seq_top`

## Requirements
- R1: After reset the mode field reads 000, data-ready (`rdy_n`) is high, the signal phase is selected and all strobes are low.
- R2: With mode code 000, or any code other than 100 and 101, each output tick is followed in the next cycle by a one-cycle `word_latch` pulse, and `rdy_n` goes low in that same cycle.
- R3: A pulse on `rd_ack` returns `rdy_n` high.
- R4: Writing code 100 selects the zero-scale phase for 3 output ticks and pulses `ofs_upd` after the 3rd tick. It then selects the full-scale phase for 3 ticks and pulses `gain_upd` after the 6th tick. The mode field reads 000 from that same cycle onward.
- R5: After the full-scale step, the signal phase is selected for 3 more ticks. No data word appears during the whole calibration. The first word and the fall of `rdy_n` come after the 9th tick.
- R6: If `rdy_n` is low when code 100 is written, it stays low until the first `mod_tick` after the write and goes high on that tick. It then stays high until the word of R5.
- R7: Writing code 101 repeats a schedule of 6 output ticks: 3 signal ticks ending in a `word_latch` pulse, then 3 zero-scale ticks ending in an `ofs_upd` pulse. In this mode `gain_upd` never pulses.
- R8: Background mode persists while the field holds 101. Rewriting 101 does not restart the schedule. Writing any other code leaves the mode at once.
- R9: In normal mode, `sync_req` sets `rdy_n` high and the next output tick yields no word. In background mode and during calibration, `sync_req` has no effect on `rdy_n` or on the schedule.
- R10: Exactly one of `phase_zs`, `phase_fs` and `phase_sig` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe that writes the mode field |
| mode_wdata | input | 3 | Mode code to write |
| out_tick | input | 1 | One-cycle pulse per output-rate period |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| sync_req | input | 1 | Filter restart request |
| rd_ack | input | 1 | Host has read the data word |
| mode_q | output | 3 | Current mode field |
| phase_zs | output | 1 | Zero-scale phase selected |
| phase_fs | output | 1 | Full-scale phase selected |
| phase_sig | output | 1 | Signal phase selected |
| ofs_upd | output | 1 | Offset coefficient update strobe |
| gain_upd | output | 1 | Gain coefficient update strobe |
| word_latch | output | 1 | New data word strobe |
| rdy_n | output | 1 | Data-ready, active low |

## Verification
The hardest situation to reach is a calibration command that arrives while data-ready is already low, followed by a modulator tick that comes only later. The bench first lets a normal-mode tick pull `rdy_n` low. It then writes code 100, holds `mod_tick` off for a few cycles and checks that the flag stays low, and only then pulses the modulator tick. The second hard case is a background schedule that is already half run, with a synchronisation request and a redundant rewrite of 101 in the middle. A scoreboard catches the shift in word timing that a wrongly restarted schedule would cause.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_NORM   = 3'b000;
   localparam logic [MODE_W-1:0] MODE_SYSOFS = 3'b100;
   localparam logic [MODE_W-1:0] MODE_BGCAL  = 3'b101;

   typedef enum logic [2:0] {
      ST_CONV,   // continuous conversion
      ST_SZS,    // system-offset: zero-scale step
      ST_SFS,    // system-offset: full-scale step
      ST_SSIG,   // system-offset: trailing signal conversion
      ST_BSIG,   // background: signal conversion
      ST_BZS     // background: zero-scale step
   } seq_state_e;
endpackage

// File: rtl/cal_step_counter.sv
module cal_step_counter #(
   parameter int STEP_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic last
);
   generate
      if (STEP_TICKS == 1) begin : g_single
         assign last = tick;
      end else begin : g_count
         localparam int CW = $clog2(STEP_TICKS);
         localparam logic [CW-1:0] LAST_V = CW'(STEP_TICKS - 1);
         logic [CW-1:0] cnt;

         assign last = tick && (cnt == LAST_V);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (clr)      cnt <= '0;
            else if (last)     cnt <= '0;
            else if (tick)     cnt <= cnt + 1'b1;
         end

         // R4: step counter never leaves its range
         a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST_V);
      end
   endgenerate
endmodule

// File: rtl/cal_rdy_ctrl.sv
module cal_rdy_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic word_new,
   input  logic cal_req,
   input  logic mod_tick,
   input  logic force_hi,
   output logic rdy_n
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n <= 1'b1;
         pend  <= 1'b0;
      end else if (word_new) begin
         rdy_n <= 1'b0;
         pend  <= 1'b0;
      end else begin
         if (force_hi) rdy_n <= 1'b1;
         if (pend && mod_tick) begin
            rdy_n <= 1'b1;
            pend  <= 1'b0;
         end else if (cal_req) begin
            pend  <= 1'b1;
         end
      end
   end

   // R6: the flag only rises on a modulator tick or an explicit release
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_n) |-> $past(mod_tick || force_hi));
   // R2: the flag only falls for a fresh word
   a_r2_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(word_new));
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
   import cal_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              out_tick,
   input  logic              sync_req,
   input  logic              step_last,
   output logic              step_clr,
   output logic              word_new,
   output logic              cal_req,
   output logic              sync_hi,
   output logic [MODE_W-1:0] mode_q,
   output logic              phase_zs,
   output logic              phase_fs,
   output logic              phase_sig,
   output logic              word_latch,
   output logic              ofs_upd,
   output logic              gain_upd
);
   seq_state_e state, nxt;
   logic in_bg, accept_wr, skip_q;
   logic ofs_ev, gain_ev, clear_mode;

   assign in_bg     = (state == ST_BSIG) || (state == ST_BZS);
   assign accept_wr = mode_wr && !(in_bg && mode_wdata == MODE_BGCAL);
   assign step_clr  = accept_wr;
   assign cal_req   = accept_wr && (mode_wdata == MODE_SYSOFS);
   assign sync_hi   = sync_req && (state == ST_CONV) && !accept_wr;

   always_comb begin
      nxt        = state;
      word_new   = 1'b0;
      ofs_ev     = 1'b0;
      gain_ev    = 1'b0;
      clear_mode = 1'b0;
      if (accept_wr) begin
         case (mode_wdata)
            MODE_SYSOFS: nxt = ST_SZS;
            MODE_BGCAL:  nxt = ST_BSIG;
            default:     nxt = ST_CONV;
         endcase
      end else begin
         case (state)
            ST_CONV: word_new = out_tick && !skip_q;
            ST_SZS:  if (step_last) begin ofs_ev = 1'b1; nxt = ST_SFS; end
            ST_SFS:  if (step_last) begin
                        gain_ev = 1'b1; clear_mode = 1'b1; nxt = ST_SSIG;
                     end
            ST_SSIG: if (step_last) begin word_new = 1'b1; nxt = ST_CONV; end
            ST_BSIG: if (step_last) begin word_new = 1'b1; nxt = ST_BZS; end
            ST_BZS:  if (step_last) begin ofs_ev = 1'b1; nxt = ST_BSIG; end
            default: nxt = ST_CONV;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_CONV;
         mode_q     <= MODE_NORM;
         skip_q     <= 1'b0;
         word_latch <= 1'b0;
         ofs_upd    <= 1'b0;
         gain_upd   <= 1'b0;
      end else begin
         state      <= nxt;
         word_latch <= word_new;
         ofs_upd    <= ofs_ev;
         gain_upd   <= gain_ev;
         if (accept_wr)       mode_q <= mode_wdata;
         else if (clear_mode) mode_q <= MODE_NORM;
         if (accept_wr)                         skip_q <= 1'b0;
         else if (sync_hi)                      skip_q <= 1'b1;
         else if (state == ST_CONV && out_tick) skip_q <= 1'b0;
      end
   end

   assign phase_zs  = (state == ST_SZS) || (state == ST_BZS);
   assign phase_fs  = (state == ST_SFS);
   assign phase_sig = !(phase_zs || phase_fs);

   // R4: the gain strobe coincides with a cleared mode field
   a_r4_clear_with_gain: assert property (@(posedge clk) disable iff (!rst_n)
      gain_upd |-> mode_q == MODE_NORM);
   // R7: background mode never updates the gain
   a_r7_bg_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
      in_bg |-> !gain_upd);
   // R5: no data word during the two calibration steps
   a_r5_no_word_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SZS || state == ST_SFS) |-> !word_latch);
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top #(
   parameter int STEP_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [2:0] mode_wdata,
   input  logic       out_tick,
   input  logic       mod_tick,
   input  logic       sync_req,
   input  logic       rd_ack,
   output logic [2:0] mode_q,
   output logic       phase_zs,
   output logic       phase_fs,
   output logic       phase_sig,
   output logic       ofs_upd,
   output logic       gain_upd,
   output logic       word_latch,
   output logic       rdy_n
);
   generate
      if (STEP_TICKS < 1 || STEP_TICKS > 255) begin : g_bad_step
         $error("cal_seq_top: STEP_TICKS out of range");
      end
   endgenerate

   logic step_last, step_clr, word_new, cal_req, sync_hi;

   cal_step_counter #(.STEP_TICKS(STEP_TICKS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (step_clr),
      .tick  (out_tick),
      .last  (step_last)
   );

   cal_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .out_tick   (out_tick),
      .sync_req   (sync_req),
      .step_last  (step_last),
      .step_clr   (step_clr),
      .word_new   (word_new),
      .cal_req    (cal_req),
      .sync_hi    (sync_hi),
      .mode_q     (mode_q),
      .phase_zs   (phase_zs),
      .phase_fs   (phase_fs),
      .phase_sig  (phase_sig),
      .word_latch (word_latch),
      .ofs_upd    (ofs_upd),
      .gain_upd   (gain_upd)
   );

   cal_rdy_ctrl u_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_new (word_new),
      .cal_req  (cal_req),
      .mod_tick (mod_tick),
      .force_hi (sync_hi || rd_ack),
      .rdy_n    (rdy_n)
   );

   // R2: a data word strobe always sees data-ready active
   a_r2_word_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      word_latch |-> !rdy_n);
   // R10: exactly one phase selected
   a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({phase_zs, phase_fs, phase_sig}) == 1);
endmodule

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
   localparam int CLK_PERIOD = 10;
   localparam int STEP = 3;

   logic clk, rst_n, mode_wr, out_tick, mod_tick, sync_req, rd_ack;
   logic [2:0] mode_wdata, mode_q;
   logic phase_zs, phase_fs, phase_sig, ofs_upd, gain_upd, word_latch, rdy_n;

   cal_seq_top #(.STEP_TICKS(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .out_tick(out_tick), .mod_tick(mod_tick), .sync_req(sync_req),
      .rd_ack(rd_ack), .mode_q(mode_q), .phase_zs(phase_zs),
      .phase_fs(phase_fs), .phase_sig(phase_sig), .ofs_upd(ofs_upd),
      .gain_upd(gain_upd), .word_latch(word_latch), .rdy_n(rdy_n)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int tick_no = 0;
   bit done = 1'b0;
   int exp_ev[$];
   string exp_tag[$];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // kind: 1 word, 2 offset update, 3 gain update
   task automatic expect_ev(int kind, int at_tick, string tag);
      exp_ev.push_back(kind * 10000 + at_tick);
      exp_tag.push_back(tag);
   endtask

   task automatic sb_pop(int kind);
      int e;
      string t;
      checks++;
      if (exp_ev.size() == 0) begin
         errors++;
         $display("FAIL R7 unexpected event actual kind %0d at tick %0d expected none",
                  kind, tick_no);
      end else begin
         e = exp_ev.pop_front();
         t = exp_tag.pop_front();
         if (e != kind * 10000 + tick_no) begin
            errors++;
            $display("FAIL %s event actual %0d expected %0d", t,
                     kind * 10000 + tick_no, e);
         end
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (word_latch) sb_pop(1);
         if (ofs_upd)    sb_pop(2);
         if (gain_upd)   sb_pop(3);
      end
   end

   task automatic tick_once();
      @(negedge clk) out_tick = 1'b1; tick_no++;
      @(negedge clk) out_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic write_mode(logic [2:0] code);
      @(negedge clk) begin mode_wr = 1'b1; mode_wdata = code; end
      @(negedge clk) mode_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk) rd_ack = 1'b1;
      @(negedge clk) rd_ack = 1'b0;
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_req = 1'b1;
      @(negedge clk) sync_req = 1'b0;
   endtask

   task automatic pulse_mod();
      @(negedge clk) mod_tick = 1'b1;
      @(negedge clk) mod_tick = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 3'b000; out_tick = 1'b0;
      mod_tick = 1'b0; sync_req = 1'b0; rd_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode_q, 0);
      chk("R1 rdy_n", rdy_n, 1);
      chk("R1 strobes", {word_latch, ofs_upd, gain_upd}, 0);
      chk("R10 phase after reset", {phase_zs, phase_fs, phase_sig}, 3'b001);

      // R2 normal conversion
      for (int i = 1; i <= 3; i++) expect_ev(1, tick_no + i, "R2");
      tick_once();
      chk("R2 rdy_n low after word", rdy_n, 0);
      tick_once();
      tick_once();
      pulse_ack();
      chk("R3 rdy_n after ack", rdy_n, 1);

      // undefined code behaves as normal
      write_mode(3'b010);
      expect_ev(1, tick_no + 1, "R2 other code");
      tick_once();

      // R9 sync in normal mode
      pulse_sync();
      chk("R9 sync sets rdy_n", rdy_n, 1);
      tick_once();                      // discarded
      expect_ev(1, tick_no + 1, "R9 word after skip");
      tick_once();
      chk("R9 rdy_n after skip word", rdy_n, 0);

      // R4/R5/R6 system-offset calibration, rdy low on entry
      expect_ev(2, tick_no + STEP,     "R4 offset strobe");
      expect_ev(3, tick_no + 2 * STEP, "R4 gain strobe");
      expect_ev(1, tick_no + 3 * STEP, "R5 first word");
      write_mode(3'b100);
      chk("R4 mode set", mode_q, 4);
      chk("R4 zero-scale phase", {phase_zs, phase_fs, phase_sig}, 3'b100);
      chk("R6 rdy_n held low", rdy_n, 0);
      repeat (3) @(negedge clk);
      chk("R6 rdy_n low before mod tick", rdy_n, 0);
      pulse_mod();
      chk("R6 rdy_n high at mod tick", rdy_n, 1);
      pulse_sync();
      for (int k = 1; k <= 3 * STEP; k++) begin
         tick_once();
         if (k < 2 * STEP) chk("R4 mode held", mode_q, 4);
         else              chk("R4 mode cleared", mode_q, 0);
         if (k == STEP + 1) chk("R4 full-scale phase", {phase_zs, phase_fs, phase_sig}, 3'b010);
         if (k == 2 * STEP + 1) chk("R5 signal phase", {phase_zs, phase_fs, phase_sig}, 3'b001);
         if (k < 3 * STEP) chk("R6 rdy_n high in cal", rdy_n, 1);
         else              chk("R5 rdy_n low after cal", rdy_n, 0);
      end

      // R7/R8/R9 background calibration
      expect_ev(1, tick_no + STEP,     "R7 bg word 1");
      expect_ev(2, tick_no + 2 * STEP, "R7 bg offset 1");
      expect_ev(1, tick_no + 3 * STEP, "R8 bg word 2");
      expect_ev(2, tick_no + 4 * STEP, "R8 bg offset 2");
      write_mode(3'b101);
      for (int k = 1; k <= 4 * STEP; k++) begin
         tick_once();
         if (k == STEP + 1) begin
            chk("R7 bg zero-scale phase", {phase_zs, phase_fs, phase_sig}, 3'b100);
            pulse_sync();
            chk("R9 sync ignored in bg", rdy_n, 0);
            write_mode(3'b101);
         end
      end
      chk("R8 mode persists", mode_q, 5);

      // leave background
      write_mode(3'b000);
      chk("R8 left bg", mode_q, 0);
      expect_ev(1, tick_no + 1, "R8 normal after bg");
      tick_once();

      repeat (3) @(negedge clk);
      chk("R7 scoreboard drained", exp_ev.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule